// File: doc/BRIEF.md
# Masked Associative Search Memory

This block is a small content-addressable store of `WORDS` entries, each `WIDTH` bits wide, with a valid flag per entry. A write port loads one entry by address and sets or clears its valid flag. A search port sends an argument, a bit mask and a mode to every entry at the same time. Each entry has its own compare logic and gives one match bit. Only bit positions whose mask bit is 1 take part in the compare. Bit positions whose mask bit is 0 always count as matching.

There are three compare modes. The first looks for equality. The other two look for entries whose masked value is above, or below, the masked argument. The block registers the match vector and the position of the lowest matching entry one cycle after the search strobe, and derives a hit flag from that vector. A controller uses it to find entries by content instead of by address, for example to locate a tag or to pick out every entry over a threshold.

Top module: `masked_assoc_mem`

## Requirements
- R1: After reset, `match_vec` is all zeros, `hit` is 0, `match_idx` is 0, and every entry is invalid. A search with mask 0 in equal mode then returns no match.
- R2: When `wr_en` is 1 at a rising clock edge, the entry at `wr_addr` takes `wr_data`, and its valid flag takes `wr_valid`. An invalid entry never reports a match in any mode.
- R3: Mode 2'b00 (equal) marks a valid entry when (entry AND mask) equals (argument AND mask). Mask bit 1 means that bit is compared. Mask bit 0 means that bit is ignored.
- R4: Mode 2'b01 (greater) marks a valid entry when (entry AND mask), read as unsigned, is strictly greater than (argument AND mask).
- R5: Mode 2'b10 (less) marks a valid entry when (entry AND mask), read as unsigned, is strictly less than (argument AND mask).
- R6: Mode 2'b11 is reserved and gives an all-zero match vector.
- R7: The result of a search strobed at edge k appears on `match_vec` and `match_idx` after edge k. Both outputs keep their values while `srch_en` is 0.
- R8: `hit` is 1 exactly when at least one bit of `match_vec` is set.
- R9: `match_idx` is the lowest set position of `match_vec`, or 0 when no bit is set.
- R10: When a write and a search happen in the same cycle, the search result uses the entry contents and valid flags from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | IDX_W | Entry to write |
| wr_data | input | WIDTH | Data to store |
| wr_valid | input | 1 | Valid flag to store with the data |
| srch_en | input | 1 | Search strobe |
| srch_arg | input | WIDTH | Search argument |
| srch_mask | input | WIDTH | Bit mask, 1 = compare this bit |
| srch_mode | input | 2 | 00 equal, 01 greater, 10 less, 11 reserved |
| match_vec | output | WORDS | Registered match bit for each entry |
| hit | output | 1 | 1 when any entry matched |
| match_idx | output | IDX_W | Lowest matching entry |

## Verification
The bench runs the search with several kinds of mask:
- An all-zero mask shows whether ignored bits really count as matching. With this mask every valid entry should match.
- A full mask shows an exact compare.
- Random partial masks check which bit positions are kept in the compare.

Entries that share their low bits but differ in their high bits separate a greater result from a less result. They also catch a compare that is not done on unsigned values.

Further cases check the remaining rules:
- Invalidated entries that hold matching data show whether the valid flag gates the match.
- A write and a search aimed at the same entry in one cycle show whether the result uses the old or the new contents.
- Idle cycles after a search show whether the result holds.

// File: rtl/cam_pkg.sv
// Shared types for the masked associative search memory.
package cam_pkg;
    // Compare mode applied to every entry during a search.
    typedef enum logic [1:0] {
        MODE_EQ  = 2'b00,
        MODE_GT  = 2'b01,
        MODE_LT  = 2'b10,
        MODE_RSV = 2'b11
    } cam_mode_e;
endpackage

// File: rtl/cam_store.sv
// Entry storage: holds WORDS data words plus one valid flag per entry.
// Assumes a single write port. An out-of-range address writes nothing.
// Reads are combinational and show the contents from before the current edge.
module cam_store #(
    parameter int WORDS = 8,
    parameter int WIDTH = 16,
    parameter int IDX_W = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_addr,
    input  logic [WIDTH-1:0]             wr_data,
    input  logic                         wr_valid,
    output logic [WORDS-1:0][WIDTH-1:0]  words,
    output logic [WORDS-1:0]             valid
);
    for (genvar g = 0; g < WORDS; g++) begin : g_entry
        logic sel;
        assign sel = wr_en && (wr_addr == IDX_W'(g));

        // Load this entry and its flag when it is addressed; clear it on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= '0;
                valid[g] <= 1'b0;
            end else if (sel) begin
                words[g] <= wr_data;
                valid[g] <= wr_valid;
            end
        end
    end
endmodule

// File: rtl/cam_match_cell.sv
// Compare logic for one entry. It masks both the entry and the argument, then
// applies the selected mode. The compare is unsigned. The reserved mode and
// an invalid entry never match.
module cam_match_cell
    import cam_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] word,
    input  logic             valid,
    input  logic [WIDTH-1:0] arg,
    input  logic [WIDTH-1:0] mask,
    input  cam_mode_e        mode,
    output logic             match
);
    logic [WIDTH-1:0] w_m;
    logic [WIDTH-1:0] a_m;
    assign w_m = word & mask;
    assign a_m = arg & mask;

    // Pick the compare result for the active mode, gated by the valid flag.
    always_comb begin
        unique case (mode)
            MODE_EQ: match = valid && (w_m == a_m);
            MODE_GT: match = valid && (w_m >  a_m);
            MODE_LT: match = valid && (w_m <  a_m);
            default: match = 1'b0;
        endcase
    end
endmodule

// File: rtl/cam_lowest_idx.sv
// Priority encoder: returns the lowest set position of the input vector.
// Returns 0 when no bit is set. The caller separates that case using an OR.
module cam_lowest_idx #(
    parameter int WORDS = 8,
    parameter int IDX_W = 3
) (
    input  logic [WORDS-1:0] vec,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top down so the lowest set bit is written last and wins.
    always_comb begin
        idx = '0;
        for (int i = WORDS - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/masked_assoc_mem.sv
// Masked associative search memory, top level.
// It sends the search pattern to one compare cell per entry. It registers the
// match vector and the lowest matching index on the search strobe and holds
// them otherwise. A write in the same cycle does not affect the search,
// because the compare reads the stored contents from before that edge.
module masked_assoc_mem
    import cam_pkg::*;
#(
    parameter int WORDS = 8,
    parameter int WIDTH = 16,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             wr_valid,
    input  logic             srch_en,
    input  logic [WIDTH-1:0] srch_arg,
    input  logic [WIDTH-1:0] srch_mask,
    input  logic [1:0]       srch_mode,
    output logic [WORDS-1:0] match_vec,
    output logic             hit,
    output logic [IDX_W-1:0] match_idx
);
    logic [WORDS-1:0][WIDTH-1:0] words;
    logic [WORDS-1:0]            valid_q;
    logic [WORDS-1:0]            match_d;
    logic [IDX_W-1:0]            idx_d;
    cam_mode_e                   mode;

    assign mode = cam_mode_e'(srch_mode);

    cam_store #(.WORDS(WORDS), .WIDTH(WIDTH), .IDX_W(IDX_W)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .wr_valid (wr_valid),
        .words    (words),
        .valid    (valid_q)
    );

    for (genvar g = 0; g < WORDS; g++) begin : g_cell
        cam_match_cell #(.WIDTH(WIDTH)) cell_i (
            .word  (words[g]),
            .valid (valid_q[g]),
            .arg   (srch_arg),
            .mask  (srch_mask),
            .mode  (mode),
            .match (match_d[g])
        );
    end

    cam_lowest_idx #(.WORDS(WORDS), .IDX_W(IDX_W)) enc_i (
        .vec (match_d),
        .idx (idx_d)
    );

    // Capture the search result on the strobe and hold it between searches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_vec <= '0;
            match_idx <= '0;
        end else if (srch_en) begin
            match_vec <= match_d;
            match_idx <= idx_d;
        end
    end

    assign hit = |match_vec;
endmodule

// File: rtl/masked_assoc_mem_chk.sv
// Checker for masked_assoc_mem. It relates the registered outputs to the
// search inputs and the stored valid flags. It is attached with bind below.
module masked_assoc_mem_chk #(
    parameter int WORDS = 8,
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             srch_en,
    input logic [1:0]       srch_mode,
    input logic [WORDS-1:0] srch_mask_zero_dummy,
    input logic             mask_is_zero,
    input logic [WORDS-1:0] valid_q,
    input logic [WORDS-1:0] match_vec,
    input logic             hit,
    input logic [IDX_W-1:0] match_idx
);
    AST_RESERVED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_en && srch_mode == 2'b11) |=> (match_vec == '0)); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_en |=> ($stable(match_vec) && $stable(match_idx))); // R7

    AST_HIT_POINTS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> match_vec[match_idx]); // R8

    AST_IDX_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((match_vec & ((WORDS'(1) << match_idx) - WORDS'(1))) == '0)); // R9

    AST_IDX_ZERO_NOHIT: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (match_idx == '0)); // R9

    AST_INVALID_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        srch_en |=> ((match_vec & ~$past(valid_q)) == '0)); // R2

    AST_ZERO_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_en && srch_mode == 2'b00 && mask_is_zero) |=> (match_vec == $past(valid_q))); // R3
endmodule

bind masked_assoc_mem masked_assoc_mem_chk #(.WORDS(WORDS), .IDX_W(IDX_W)) chk_i (
    .clk                  (clk),
    .rst_n                (rst_n),
    .srch_en              (srch_en),
    .srch_mode            (srch_mode),
    .srch_mask_zero_dummy (match_d),
    .mask_is_zero         (srch_mask == '0),
    .valid_q              (valid_q),
    .match_vec            (match_vec),
    .hit                  (hit),
    .match_idx            (match_idx)
);

// File: tb/masked_assoc_mem_tb_top.sv
// Self-checking bench: a reference model of the entries, directed corner
// cases and seeded random operations.
module masked_assoc_mem_tb_top;
    localparam int WORDS = 8;
    localparam int WIDTH = 16;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [IDX_W-1:0] wr_addr = '0;
    logic [WIDTH-1:0] wr_data = '0;
    logic             wr_valid = 1'b0;
    logic             srch_en = 1'b0;
    logic [WIDTH-1:0] srch_arg = '0;
    logic [WIDTH-1:0] srch_mask = '0;
    logic [1:0]       srch_mode = 2'b00;
    logic [WORDS-1:0] match_vec;
    logic             hit;
    logic [IDX_W-1:0] match_idx;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [WIDTH-1:0] mdl_data [WORDS];
    logic             mdl_valid [WORDS];
    logic [WORDS-1:0] exp_vec = '0;

    always #10 clk = ~clk;

    masked_assoc_mem #(.WORDS(WORDS), .WIDTH(WIDTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_valid(wr_valid), .srch_en(srch_en),
        .srch_arg(srch_arg), .srch_mask(srch_mask), .srch_mode(srch_mode),
        .match_vec(match_vec), .hit(hit), .match_idx(match_idx)
    );

    function automatic logic [WORDS-1:0] model_search(logic [WIDTH-1:0] a,
            logic [WIDTH-1:0] m, logic [1:0] md);
        logic [WORDS-1:0] v = '0;
        for (int i = 0; i < WORDS; i++) begin
            logic [WIDTH-1:0] w = mdl_data[i] & m;
            logic [WIDTH-1:0] x = a & m;
            if (mdl_valid[i]) begin
                case (md)
                    2'b00: v[i] = (w == x);
                    2'b01: v[i] = (w > x);
                    2'b10: v[i] = (w < x);
                    default: v[i] = 1'b0;
                endcase
            end
        end
        return v;
    endfunction

    function automatic logic [IDX_W-1:0] model_idx(logic [WORDS-1:0] v);
        for (int i = 0; i < WORDS; i++) if (v[i]) return IDX_W'(i);
        return '0;
    endfunction

    task automatic check_out(string req);
        checks++;
        if (match_vec !== exp_vec || hit !== (|exp_vec) || match_idx !== model_idx(exp_vec)) begin
            fails++;
            $display("FAIL %s: vec=%b hit=%b idx=%0d expected vec=%b hit=%b idx=%0d",
                     req, match_vec, hit, match_idx, exp_vec, |exp_vec, model_idx(exp_vec));
        end
    endtask

    // One cycle: optional write and optional search, driven at negedge.
    task automatic step(bit do_wr, int unsigned addr, logic [WIDTH-1:0] d, bit v,
                        bit do_s, logic [WIDTH-1:0] a, logic [WIDTH-1:0] m, logic [1:0] md);
        wr_en = do_wr; wr_addr = IDX_W'(addr); wr_data = d; wr_valid = v;
        srch_en = do_s; srch_arg = a; srch_mask = m; srch_mode = md;
        if (do_s) exp_vec = model_search(a, m, md);
        @(posedge clk);
        if (do_wr) begin
            mdl_data[addr] = d;
            mdl_valid[addr] = v;
        end
        @(negedge clk);
        wr_en = 1'b0; srch_en = 1'b0;
    endtask

    task automatic wr(int unsigned addr, logic [WIDTH-1:0] d, bit v);
        step(1'b1, addr, d, v, 1'b0, '0, '0, 2'b00);
    endtask

    task automatic srch(logic [WIDTH-1:0] a, logic [WIDTH-1:0] m, logic [1:0] md, string req);
        step(1'b0, 0, '0, 1'b0, 1'b1, a, m, md);
        check_out(req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5813));
        for (int i = 0; i < WORDS; i++) begin
            mdl_data[i] = '0;
            mdl_valid[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_vec = '0;
        check_out("R1 reset outputs");
        srch('0, '0, 2'b00, "R1 all invalid after reset");

        // R2 load entries, then an invalidated entry stays silent.
        for (int i = 0; i < WORDS; i++) wr(i, 16'h00A0 + 16'(i), 1'b1);
        srch('0, '0, 2'b00, "R3 zero mask matches all valid");
        wr(0, 16'h00A0, 1'b0);
        srch(16'h00A0, 16'hFFFF, 2'b00, "R2 invalid entry never matches");
        srch('0, '0, 2'b01, "R2 zero mask gt gives none");

        // R3 partial mask: low nibble ignored.
        srch(16'h00AF, 16'hFFF0, 2'b00, "R3 masked equal");
        srch(16'h00A3, 16'hFFFF, 2'b00, "R3 full mask exact");

        // R4/R5 unsigned compare with high-bit difference.
        wr(5, 16'h8000, 1'b1);
        srch(16'h00A3, 16'hFFFF, 2'b01, "R4 greater than");
        srch(16'h00A3, 16'hFFFF, 2'b10, "R5 less than");
        srch(16'h7FFF, 16'h8000, 2'b01, "R4 masked greater");

        // R6 reserved mode.
        srch('0, '0, 2'b11, "R6 reserved mode empty");

        // R7 hold across idle cycles, even with inputs changing.
        srch(16'h00A3, 16'hFFFF, 2'b10, "R7 result after strobe");
        srch_arg = 16'hFFFF; srch_mode = 2'b01;
        repeat (3) @(negedge clk);
        check_out("R7 hold while idle");

        // R10 write and search to the same entry in one cycle.
        step(1'b1, 2, 16'h1234, 1'b1, 1'b1, 16'h00A2, 16'hFFFF, 2'b00);
        check_out("R10 search sees old contents");
        srch(16'h1234, 16'hFFFF, 2'b00, "R10 new contents visible next");
        step(1'b1, 3, 16'h00A3, 1'b0, 1'b1, 16'h00A3, 16'hFFFF, 2'b00);
        check_out("R10 old valid flag used");

        // R8/R9 multiple matches pick the lowest index.
        wr(6, 16'h1234, 1'b1);
        srch(16'h1234, 16'hFFFF, 2'b00, "R9 lowest index of two");

        // Random mix.
        for (int n = 0; n < 400; n++) begin
            int unsigned r = $urandom % 4;
            logic [WIDTH-1:0] d = (($urandom % 2) != 0) ? WIDTH'($urandom % 16) : WIDTH'($urandom);
            logic [WIDTH-1:0] m;
            case ($urandom % 3)
                0: m = '0;
                1: m = '1;
                default: m = WIDTH'($urandom);
            endcase
            if (r == 0) begin
                wr($urandom % WORDS, d, ($urandom % 5) != 0);
            end else if (r == 1) begin
                step(1'b1, $urandom % WORDS, d, 1'b1, 1'b1, WIDTH'($urandom % 16), m, 2'($urandom));
                check_out("R10 random write with search");
            end else begin
                srch(d, m, 2'($urandom), "R3 R4 R5 R6 R8 R9 random search");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule